// File: doc/BRIEF.md
# Run-time signed/unsigned multiply-accumulator

This block forms the product of two operands and folds it into a running sum, either adding or subtracting it each enabled clock. Each operand has its own run-time flag that says whether its bits are a two's complement number or an unsigned number, so one instance serves signed, unsigned and mixed-sign filter taps without reconfiguration.

A restart input throws away the running sum and starts again from the current product. The starting value is either zero or a preset placed in the most significant bits with zeros below it. The product is negated when the block is in subtract mode. A sticky flag records that the signed sum has wrapped since the last restart. There is one clock, one clock enable and one asynchronous active-low clear. Operands and controls pass through one input register stage and then one accumulator stage, so the inputs reach `acc_out` two clock edges after they are presented.

Top module: `mac_accum`

## Requirements
- R1: While `rst_n` is low, `acc_out` is 0 and `acc_ovf` is 0. The clear acts without waiting for a clock edge. After `rst_n` rises, the internal clear is held for two more rising edges.
- R2: When `a_is_signed` is 1, `op_a` is read as two's complement; when it is 0, `op_a` is read as unsigned. `b_is_signed` does the same for `op_b`. The product is exact for all four combinations and is sign-extended to WR bits.
- R3: When `add_sel` is 1 and `restart` is 0, the accumulator becomes its old value plus the product.
- R4: When `add_sel` is 0 and `restart` is 0, the accumulator becomes its old value minus the product.
- R5: When `restart` is 1 and `seed_sel` is 0, the accumulator becomes the product, or its negation when `add_sel` is 0.
- R6: When `restart` is 1 and `seed_sel` is 1, the accumulator becomes `{seed_hi, WR-WP zero bits}` plus the product, or minus the product when `add_sel` is 0.
- R7: Operands and controls sampled at rising edge k appear in `acc_out` after rising edge k+1.
- R8: While `ce` is 0, every register holds its value. Inputs presented in those cycles are never used, and the `acc_out` and `acc_ovf` values do not change.
- R9: `acc_ovf` is set when a signed WR-bit accumulate wraps. It stays set on later non-restart updates. A restart loads it with the wrap status of the restart update alone.
- R10: On wrap, `acc_out` holds the exact result modulo 2^WR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear of all registers |
| ce | input | 1 | Clock enable; 0 freezes every register |
| op_a | input | WA | First multiplier operand |
| op_b | input | WB | Second multiplier operand |
| a_is_signed | input | 1 | 1: `op_a` is two's complement, 0: unsigned |
| b_is_signed | input | 1 | 1: `op_b` is two's complement, 0: unsigned |
| add_sel | input | 1 | 1: add product, 0: subtract product |
| restart | input | 1 | 1: replace the feedback with the seed |
| seed_sel | input | 1 | Seed on restart, 0: zero, 1: preset upper value |
| seed_hi | input | WP | Preset placed in the top WP bits of the seed |
| acc_out | output | WR | Accumulator value |
| acc_ovf | output | 1 | Sticky signed-wrap flag |

## Verification
The bench attacks the extreme products: unsigned 255×255, mixed-sign 255×-128 and signed -128×-128. A multiplier that dropped the extra product bit or extended with the wrong sign would produce a wrong sum on the next cycle. Long runs of full-scale adds and subtracts push the sum past both signed limits. A design with a non-sticky flag would drop `acc_ovf` on the next quiet update, and a design that never cleared it on restart would keep it high after reseeding. Restarts with negative and positive presets in both directions catch a seed put in the wrong bit field or left un-negated. Freezes with busy inputs, including restart pulses, catch any register that still loads while `ce` is low.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Control bits that travel alongside the operands through the input stage
  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic add;
    logic restart;
    logic seed_sel;
  } mac_ctl_t;

  // Two's complement wrap: the two top bits of a one-bit-wider sum disagree
  function automatic logic sum_wrapped(input logic [1:0] top_bits);
    return top_bits[1] ^ top_bits[0];
  endfunction

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/mac_in_stage.sv
module mac_in_stage
  import mac_pkg::*;
#(
  parameter int WA = 8,
  parameter int WB = 8,
  parameter int WP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [WA-1:0] a_d,
  input  logic [WB-1:0] b_d,
  input  mac_ctl_t      ctl_d,
  input  logic [WP-1:0] pre_d,
  output logic [WA-1:0] a_q,
  output logic [WB-1:0] b_q,
  output mac_ctl_t      ctl_q,
  output logic [WP-1:0] pre_q
);

  logic [WA-1:0] a_nx;
  logic [WB-1:0] b_nx;
  mac_ctl_t      ctl_nx;
  logic [WP-1:0] pre_nx;

  always_comb begin
    if (ce) begin
      a_nx   = a_d;
      b_nx   = b_d;
      ctl_nx = ctl_d;
      pre_nx = pre_d;
    end else begin
      a_nx   = a_q;
      b_nx   = b_q;
      ctl_nx = ctl_q;
      pre_nx = pre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
      pre_q <= '0;
    end else begin
      a_q   <= a_nx;
      b_q   <= b_nx;
      ctl_q <= ctl_nx;
      pre_q <= pre_nx;
    end
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int WA = 8,
  parameter int WB = 8,
  parameter int WR = 24
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  input  logic          a_signed,
  input  logic          b_signed,
  output logic [WR-1:0] prod_ext
);

  localparam int PW = WA + WB + 1;

  logic signed [WA:0]      ea;
  logic signed [WB:0]      eb;
  logic signed [WA+WB+1:0] full;
  logic [PW-1:0]           prod;

  always_comb begin
    ea   = {a_signed & a[WA-1], a};
    eb   = {b_signed & b[WB-1], b};
    full = ea * eb;
    prod = full[PW-1:0];
  end

  generate
    if (WR > PW) begin : g_widen
      assign prod_ext = {{(WR-PW){prod[PW-1]}}, prod};
    end else begin : g_fit
      assign prod_ext = prod[WR-1:0];
    end
  endgenerate

endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int WR = 24,
  parameter int WP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  mac_ctl_t      ctl,
  input  logic [WP-1:0] pre,
  input  logic [WR-1:0] p_ext,
  output logic [WR-1:0] acc_q,
  output logic          ovf_q
);

  logic [WR-1:0] seed;
  logic [WR-1:0] fb;
  logic [WR:0]   sum;
  logic          wrap;
  logic [WR-1:0] acc_d;
  logic          ovf_d;

  generate
    if (WR > WP) begin : g_pad
      assign seed = {pre, {(WR-WP){1'b0}}};
    end else begin : g_trim
      assign seed = pre[WP-1 -: WR];
    end
  endgenerate

  always_comb begin
    if (ctl.restart) begin
      fb = ctl.seed_sel ? seed : '0;
    end else begin
      fb = acc_q;
    end
    if (ctl.add) begin
      sum = {fb[WR-1], fb} + {p_ext[WR-1], p_ext};
    end else begin
      sum = {fb[WR-1], fb} - {p_ext[WR-1], p_ext};
    end
    wrap = sum_wrapped(sum[WR:WR-1]);
  end

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (ce) begin
      acc_d = sum[WR-1:0];
      ovf_d = ctl.restart ? wrap : (ovf_q | wrap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int WA = 8,
  parameter int WB = 8,
  parameter int WR = 24,
  parameter int WP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [WA-1:0] op_a,
  input  logic [WB-1:0] op_b,
  input  logic          a_is_signed,
  input  logic          b_is_signed,
  input  logic          add_sel,
  input  logic          restart,
  input  logic          seed_sel,
  input  logic [WP-1:0] seed_hi,
  output logic [WR-1:0] acc_out,
  output logic          acc_ovf
);

  logic          rst_s;
  mac_ctl_t      ctl_in;
  mac_ctl_t      s1_ctl;
  logic [WA-1:0] s1_a;
  logic [WB-1:0] s1_b;
  logic [WP-1:0] s1_pre;
  logic [WR-1:0] p_ext;

  always_comb begin
    ctl_in.a_signed = a_is_signed;
    ctl_in.b_signed = b_is_signed;
    ctl_in.add      = add_sel;
    ctl_in.restart  = restart;
    ctl_in.seed_sel = seed_sel;
  end

  mac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  mac_in_stage #(.WA(WA), .WB(WB), .WP(WP)) u_in (
    .clk   (clk),
    .rst_n (rst_s),
    .ce    (ce),
    .a_d   (op_a),
    .b_d   (op_b),
    .ctl_d (ctl_in),
    .pre_d (seed_hi),
    .a_q   (s1_a),
    .b_q   (s1_b),
    .ctl_q (s1_ctl),
    .pre_q (s1_pre)
  );

  mac_mult #(.WA(WA), .WB(WB), .WR(WR)) u_mul (
    .a        (s1_a),
    .b        (s1_b),
    .a_signed (s1_ctl.a_signed),
    .b_signed (s1_ctl.b_signed),
    .prod_ext (p_ext)
  );

  mac_acc #(.WR(WR), .WP(WP)) u_acc (
    .clk   (clk),
    .rst_n (rst_s),
    .ce    (ce),
    .ctl   (s1_ctl),
    .pre   (s1_pre),
    .p_ext (p_ext),
    .acc_q (acc_out),
    .ovf_q (acc_ovf)
  );

endmodule

// File: rtl/mac_accum_chk.sv
module mac_accum_chk #(
  parameter int WR = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_s,
  input logic          ce,
  input logic          s1_restart,
  input logic          s1_add,
  input logic          s1_seed_sel,
  input logic [WR-1:0] p_ext,
  input logic [WR-1:0] acc_out,
  input logic          acc_ovf
);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (acc_out == '0 && acc_ovf == 1'b0)
        else $error("accumulator not cleared in reset");
    end
  end

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_s)
    !ce |=> ($stable(acc_out) && $stable(acc_ovf)));

  // R3
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_s)
    (ce && !s1_restart && s1_add) |=> (acc_out == $past(acc_out) + $past(p_ext)));

  // R4
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_s)
    (ce && !s1_restart && !s1_add) |=> (acc_out == $past(acc_out) - $past(p_ext)));

  // R5
  zero_seed_add_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_s)
    (ce && s1_restart && !s1_seed_sel && s1_add) |=> (acc_out == $past(p_ext)));

  // R5
  zero_seed_sub_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_s)
    (ce && s1_restart && !s1_seed_sel && !s1_add) |=> (acc_out == WR'(0) - $past(p_ext)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_s)
    (ce && !s1_restart && acc_ovf) |=> acc_ovf);

endmodule

bind mac_accum mac_accum_chk #(.WR(WR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_s       (rst_s),
  .ce          (ce),
  .s1_restart  (s1_ctl.restart),
  .s1_add      (s1_ctl.add),
  .s1_seed_sel (s1_ctl.seed_sel),
  .p_ext       (p_ext),
  .acc_out     (acc_out),
  .acc_ovf     (acc_ovf)
);

// File: tb/sim_mac_accum.sv
`timescale 1ns/1ps
module sim_mac_accum;

  localparam int WA = 8;
  localparam int WB = 8;
  localparam int WR = 24;
  localparam int WP = 8;
  localparam longint FULLR = 64'sd1 << WR;
  localparam longint HALFR = 64'sd1 << (WR - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic [WA-1:0] op_a = '0;
  logic [WB-1:0] op_b = '0;
  logic          a_is_signed = 1'b0;
  logic          b_is_signed = 1'b0;
  logic          add_sel = 1'b0;
  logic          restart = 1'b0;
  logic          seed_sel = 1'b0;
  logic [WP-1:0] seed_hi = '0;
  logic [WR-1:0] acc_out;
  logic          acc_ovf;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    running = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mac_accum #(.WA(WA), .WB(WB), .WR(WR), .WP(WP)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op_a(op_a), .op_b(op_b),
    .a_is_signed(a_is_signed), .b_is_signed(b_is_signed),
    .add_sel(add_sel), .restart(restart), .seed_sel(seed_sel),
    .seed_hi(seed_hi), .acc_out(acc_out), .acc_ovf(acc_ovf)
  );

  // Behavioural reference: one register of held inputs, then the sum
  longint m_a, m_b, m_pre, m_acc, va, vb, prod, fb, sum;
  bit     m_sa, m_sb, m_add, m_ld, m_sel, m_ovf, wr;

  function automatic longint to_signed_r(input longint x);
    longint y;
    y = ((x % FULLR) + FULLR) % FULLR;
    return (y >= HALFR) ? y - FULLR : y;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_pre = 0; m_acc = 0;
      m_sa = 0; m_sb = 0; m_add = 0; m_ld = 0; m_sel = 0; m_ovf = 0;
    end else if (ce) begin
      va   = (m_sa && m_a >= 128) ? m_a - 256 : m_a;
      vb   = (m_sb && m_b >= 128) ? m_b - 256 : m_b;
      prod = va * vb;
      if (m_ld) fb = m_sel ? to_signed_r(m_pre << (WR - WP)) : 0;
      else      fb = m_acc;
      sum   = m_add ? fb + prod : fb - prod;
      wr    = (sum >= HALFR) || (sum < -HALFR);
      m_ovf = m_ld ? wr : (m_ovf | wr);
      m_acc = to_signed_r(sum);
      m_a = longint'(op_a); m_b = longint'(op_b); m_pre = longint'(seed_hi);
      m_sa = a_is_signed; m_sb = b_is_signed; m_add = add_sel;
      m_ld = restart; m_sel = seed_sel;
    end
  end

  // Compare against the reference on every falling edge
  always @(negedge clk) begin
    if (running) begin
      logic [WR-1:0] exp_acc;
      exp_acc = m_acc[WR-1:0];
      n_chk++;
      if (acc_out !== exp_acc || acc_ovf !== m_ovf) begin
        n_fail++;
        $display("FAIL %s: acc_out=%h acc_ovf=%b expected acc_out=%h acc_ovf=%b",
                 cur_req, acc_out, acc_ovf, exp_acc, m_ovf);
      end
    end
  end

  task automatic drv(input int a, input int b, input bit sa, input bit sb,
                     input bit ad, input bit ld, input bit sel, input int pre,
                     input bit en);
    @(negedge clk);
    op_a = a[WA-1:0]; op_b = b[WB-1:0];
    a_is_signed = sa; b_is_signed = sb; add_sel = ad;
    restart = ld; seed_sel = sel; seed_hi = pre[WP-1:0]; ce = en;
  endtask

  task automatic idle(input int n, input bit en);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 1, 0, 0, 0, en);
  endtask

  task automatic direct_check(input string req, input logic [WR-1:0] exp_acc,
                              input logic exp_ovf);
    n_chk++;
    if (acc_out !== exp_acc || acc_ovf !== exp_ovf) begin
      n_fail++;
      $display("FAIL %s: acc_out=%h acc_ovf=%b expected acc_out=%h acc_ovf=%b",
               req, acc_out, acc_ovf, exp_acc, exp_ovf);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: cleared state while reset is held
    repeat (3) @(negedge clk);
    direct_check("R1", '0, 1'b0);
    running = 1'b1;
    rst_n = 1'b1;
    idle(3, 0);

    // R5 / R7: zero-seed restart, result lands two edges later
    cur_req = "R7";
    drv(13, 7, 0, 0, 1, 1, 0, 0, 1);
    idle(1, 1);
    direct_check("R7", 24'd0, 1'b0);
    @(negedge clk);
    direct_check("R7", 24'd91, 1'b0);
    cur_req = "R5";
    drv(9, 9, 0, 0, 0, 1, 0, 0, 1);
    idle(2, 1);

    // R3: unsigned adds
    cur_req = "R3";
    drv(20, 30, 0, 0, 1, 1, 0, 0, 1);
    for (int i = 0; i < 12; i++)
      drv($urandom_range(255), $urandom_range(255), 0, 0, 1, 0, 0, 0, 1);

    // R4: unsigned subtracts
    cur_req = "R4";
    for (int i = 0; i < 12; i++)
      drv($urandom_range(255), $urandom_range(255), 0, 0, 0, 0, 0, 0, 1);

    // R2: extreme and mixed-sign products
    cur_req = "R2";
    drv(255, 128, 0, 1, 1, 1, 0, 0, 1);
    drv(128, 128, 1, 1, 1, 0, 0, 0, 1);
    drv(128, 255, 1, 0, 0, 0, 0, 0, 1);
    drv(255, 255, 1, 1, 1, 0, 0, 0, 1);
    drv(255, 255, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 40; i++)
      drv($urandom_range(255), $urandom_range(255), $urandom_range(1) == 1,
          $urandom_range(1) == 1, $urandom_range(1) == 1,
          $urandom_range(7) == 0, 0, 0, 1);

    // R6: preset seeds, positive and negative, both directions
    cur_req = "R6";
    drv(100, 3, 0, 0, 1, 1, 1, 8'h40, 1);
    drv(5, 5, 0, 0, 1, 0, 0, 0, 1);
    drv(200, 2, 0, 1, 0, 1, 1, 8'h80, 1);
    drv(7, 250, 1, 0, 1, 0, 0, 0, 1);
    drv(255, 255, 0, 0, 0, 1, 1, 8'h01, 1);
    drv(255, 255, 0, 0, 1, 1, 1, 8'h7F, 1);
    for (int i = 0; i < 6; i++) drv(255, 255, 0, 0, 1, 0, 0, 0, 1);

    // R9 / R10: climb past the positive limit, stay sticky, clear on restart
    cur_req = "R10";
    drv(255, 255, 0, 0, 1, 1, 0, 0, 1);
    for (int i = 0; i < 140; i++) drv(255, 255, 0, 0, 1, 0, 0, 0, 1);
    cur_req = "R9";
    idle(4, 1);
    drv(2, 3, 0, 0, 1, 1, 0, 0, 1);
    idle(3, 1);
    drv(255, 255, 0, 0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 140; i++) drv(255, 255, 0, 0, 0, 0, 0, 0, 1);
    idle(3, 1);

    // R8: freeze with busy inputs, then release and drain
    cur_req = "R8";
    drv(17, 19, 0, 0, 1, 1, 0, 0, 1);
    drv(33, 44, 0, 0, 1, 0, 0, 0, 1);
    for (int i = 0; i < 16; i++)
      drv($urandom_range(255), $urandom_range(255), 1, 1, $urandom_range(1) == 1,
          $urandom_range(1) == 1, 1, 8'h55, 0);
    idle(4, 1);

    // R1: asynchronous clear in mid-run
    cur_req = "R1";
    drv(90, 90, 0, 0, 1, 0, 0, 0, 1);
    @(negedge clk);
    #3 rst_n = 1'b0;
    ce = 1'b0;
    @(negedge clk);
    direct_check("R1", '0, 1'b0);
    rst_n = 1'b1;
    idle(3, 0);
    cur_req = "R3";
    drv(11, 12, 0, 0, 1, 1, 0, 0, 1);
    drv(11, 12, 0, 0, 1, 0, 0, 0, 1);
    idle(3, 1);

    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule